// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Framing Check

This block receives asynchronous serial frames on a single line that idles high. A frame is a low start bit, eight data bits sent least significant bit first, an optional ninth data bit, and a high stop bit. The line is oversampled by a one-cycle baud enable pulsing sixteen times per bit. Each received byte goes to a data output. In the nine-bit formats the extra bit is latched into the control register. A receive flag reports that a frame has arrived.

An enable input turns on stop-bit checking. When it is on, a frame whose stop bit samples low sets a sticky error flag. The same enable moves the receive flag from the middle of the last data bit to the middle of the stop bit. The error flag has no control register bit of its own. It shares the top bit with the upper format-select bit, and the enable decides which of the two is read and written there. The format-select bit keeps its value in its own register while the top bit shows the error flag.

Top module: `uart_fe_rx`

## Requirements
- R1: After a synchronous reset, `ctrl_rdata` reads 0x00 whatever `fchk_en` is, and `rx_data` reads 0x00.
- R2: The format field is {bit 7 as the format-select bit, bit 6}. Format 01 receives 8 data bits, LSB first. Formats 10 and 11 receive 9 bits, and the ninth bit is latched into control bit 2. The eight low bits appear on `rx_data`.
- R3: Each bit is the majority of three line samples taken on ticks 7, 8 and 9 of its 16-tick period (tick 0 is the tick that finds the start bit low). A disturbance that lasts one tick does not change the received bit.
- R4: A start is accepted only on a high-to-low transition of the line that is still low on tick 8. Otherwise the receiver goes back to idle with no flag and no data change.
- R5: The receive flag (control bit 0) is set in the same cycle that `rx_data` is loaded. With `fchk_en`=0 this happens at the vote of the last data bit. With `fchk_en`=1 it happens at the vote of the stop bit.
- R6: With `fchk_en`=1, a stop bit that votes 0 sets the framing-error flag.
- R7: The framing-error flag is cleared only by reset or by a write of 0 to bit 7 while `fchk_en`=1. A later frame with a valid stop bit leaves it set.
- R8: With `fchk_en`=1, bit 7 reads and writes the framing-error flag and leaves the format-select bit unchanged. With `fchk_en`=0, bit 7 reads and writes the format-select bit and leaves the error flag unchanged.
- R9: A control write loads bit 0 into the receive flag. Hardware only ever sets the flag.
- R10: With the receive-enable bit (control bit 4) at 0, or with format 00, incoming frames set no flag and leave `rx_data` unchanged.
- R11: With `fchk_en`=0, a stop bit that samples low does not set the framing-error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable, 16 per bit period |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| fchk_en | input | 1 | Enables the stop-bit check and maps bit 7 to the error flag |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| rx_data | output | 8 | Last received data byte |

## Verification
The line passes through two synchronizer flops, and the first low tick becomes tick 0. The receiver therefore runs about one tick behind the bit grid the bench drives. The flag and the data load at the vote tick (tick 9 of the relevant bit) plus two clocks: one for the vote register and one for the control register. The bench checks the receive flag a quarter of the way into the stop bit. At that point it must already be set when the check is off and must still be clear when the check is on. The data, the ninth bit and the error flag are checked only after the stop bit and a short idle gap, well past every due cycle. All samples are taken on falling clock edges.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int CTRL_W     = 8;
  localparam int CB_FLAG    = 0;
  localparam int CB_NINTH   = 2;
  localparam int CB_RXEN    = 4;
  localparam int CB_FMT_LO  = 6;
  localparam int CB_SHARED  = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_fe_sync.sv
module uart_fe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_fe_frame.sv
module uart_fe_frame
  import uart_fe_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          rx_go,
  input  logic          nine_sel,
  input  logic          chk_on,
  output logic          done,
  output logic          stop_bad,
  output logic          done_nine,
  output logic [DW:0]   done_word
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] T_PRE  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] T_MID  = CW'(OVS / 2);
  localparam logic [CW-1:0] T_POST = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] T_END  = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_S = BW'(DW - 1);
  localparam logic [BW-1:0] LAST_L = BW'(DW);

  rx_state_e     st;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bidx;
  logic          armed;
  logic          nine_q;
  logic          chk_q;
  logic          samp_a;
  logic          samp_b;
  logic [DW:0]   shreg;
  logic          vote;
  logic          is_last;

  assign vote    = vote3(samp_a, samp_b, rxd);
  assign is_last = (bidx == (nine_q ? LAST_L : LAST_S));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      armed    <= 1'b0;
      nine_q   <= 1'b0;
      chk_q    <= 1'b0;
      samp_a   <= 1'b1;
      samp_b   <= 1'b1;
      shreg    <= '0;
      done     <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      done     <= 1'b0;
      stop_bad <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          tcnt <= '0;
          if (rxd) begin
            armed <= 1'b1;
          end else begin
            armed <= 1'b0;
            if (armed && rx_go) begin
              st     <= ST_START;
              tcnt   <= CW'(1);
              bidx   <= '0;
              nine_q <= nine_sel;
              chk_q  <= chk_on;
            end
          end
        end else begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == T_PRE) samp_a <= rxd;
          if (tcnt == T_MID) samp_b <= rxd;
          if (st == ST_START && tcnt == T_MID && rxd) begin
            st   <= ST_IDLE;
            tcnt <= '0;
          end else if (tcnt == T_POST) begin
            if (st == ST_DATA) begin
              shreg[bidx] <= vote;
              if (is_last && !chk_q) done <= 1'b1;
            end else if (st == ST_STOP) begin
              st    <= ST_IDLE;
              tcnt  <= '0;
              armed <= vote;
              if (chk_q) begin
                done     <= 1'b1;
                stop_bad <= !vote;
              end
            end
          end else if (tcnt == T_END) begin
            tcnt <= '0;
            if (st == ST_START) begin
              st <= ST_DATA;
            end else if (st == ST_DATA) begin
              if (is_last) st <= ST_STOP;
              else         bidx <= bidx + 1'b1;
            end
          end
        end
      end
    end
  end

  assign done_word = shreg;
  assign done_nine = nine_q;
endmodule

// File: rtl/uart_fe_ctrl.sv
module uart_fe_ctrl
  import uart_fe_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              chk_on,
  input  logic              hw_done,
  input  logic              hw_bad,
  input  logic              hw_nine,
  input  logic [DW:0]       hw_word,
  output logic [CTRL_W-1:0] rdata,
  output logic [DW-1:0]     data_q,
  output logic              fmt_hi,
  output logic              fmt_lo,
  output logic              rx_en,
  output logic              ferr,
  output logic              flag
);
  logic ninth;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_hi <= 1'b0;
      fmt_lo <= 1'b0;
      rx_en  <= 1'b0;
      ferr   <= 1'b0;
      flag   <= 1'b0;
      ninth  <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr) begin
        if (chk_on) ferr   <= wdata[CB_SHARED];
        else        fmt_hi <= wdata[CB_SHARED];
        fmt_lo <= wdata[CB_FMT_LO];
        rx_en  <= wdata[CB_RXEN];
        ninth  <= wdata[CB_NINTH];
        flag   <= wdata[CB_FLAG];
      end
      if (hw_done) begin
        flag   <= 1'b1;
        data_q <= hw_word[DW-1:0];
        if (hw_nine) ninth <= hw_word[DW];
      end
      if (hw_bad) ferr <= 1'b1;
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[CB_SHARED] = chk_on ? ferr : fmt_hi;
    rdata[CB_FMT_LO] = fmt_lo;
    rdata[CB_RXEN]   = rx_en;
    rdata[CB_NINTH]  = ninth;
    rdata[CB_FLAG]   = flag;
  end
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              rxd_in,
  input  logic              fchk_en,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output logic [DW-1:0]     rx_data
);
  logic          rxd_s;
  logic          frm_done;
  logic          frm_bad;
  logic          frm_nine;
  logic [DW:0]   frm_word;
  logic          fmt_hi;
  logic          fmt_lo;
  logic          rx_en;
  logic          ferr_q;
  logic          flag_q;
  logic          rx_go;

  assign rx_go = rx_en & (fmt_hi | fmt_lo);

  uart_fe_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd_in),
    .dout(rxd_s)
  );

  uart_fe_frame #(
    .OVS(OVS),
    .DW (DW)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud_tick),
    .rxd      (rxd_s),
    .rx_go    (rx_go),
    .nine_sel (fmt_hi),
    .chk_on   (fchk_en),
    .done     (frm_done),
    .stop_bad (frm_bad),
    .done_nine(frm_nine),
    .done_word(frm_word)
  );

  uart_fe_ctrl #(
    .DW(DW)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr     (ctrl_wr),
    .wdata  (ctrl_wdata),
    .chk_on (fchk_en),
    .hw_done(frm_done),
    .hw_bad (frm_bad),
    .hw_nine(frm_nine),
    .hw_word(frm_word),
    .rdata  (ctrl_rdata),
    .data_q (rx_data),
    .fmt_hi (fmt_hi),
    .fmt_lo (fmt_lo),
    .rx_en  (rx_en),
    .ferr   (ferr_q),
    .flag   (flag_q)
  );
endmodule

// File: rtl/uart_fe_rx_chk.sv
module uart_fe_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ctrl_wr,
  input logic          fchk_en,
  input logic          ferr,
  input logic          flag,
  input logic          done,
  input logic          stop_bad,
  input logic [DW-1:0] rx_data
);
  // R7: the error flag only falls through a write while the check is enabled
  assert_ferr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ferr) |-> $past(ctrl_wr && fchk_en));

  // R6: the error flag rises only from a bad stop vote or a write
  assert_ferr_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ferr) |-> $past(stop_bad || (ctrl_wr && fchk_en)));

  // R6: a bad stop report always comes with a frame completion
  assert_bad_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    stop_bad |-> done);

  // R5: the receive flag rises only from frame completion or a write
  assert_flag_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(done || ctrl_wr));

  // R5: the data output changes only on frame completion
  assert_data_load_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> $past(done));

  // R2: frame completion is a single-cycle event
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind uart_fe_rx uart_fe_rx_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctrl_wr (ctrl_wr),
  .fchk_en (fchk_en),
  .ferr    (ferr_q),
  .flag    (flag_q),
  .done    (frm_done),
  .stop_bad(frm_bad),
  .rx_data (rx_data)
);

// File: tb/uart_fe_rx_bench.sv
module uart_fe_rx_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] tdiv = 2'd0;
  logic       baud_tick;
  logic       rxd_in;
  logic       fchk_en;
  logic       ctrl_wr;
  logic [7:0] ctrl_wdata;
  logic [7:0] ctrl_rdata;
  logic [7:0] rx_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model of the programmer-visible state
  logic mh, ml, en, nin, flg, fe;
  logic [7:0] dexp;

  always #5 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd3);

  uart_fe_rx u_uart_fe_rx (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .rxd_in    (rxd_in),
    .fchk_en   (fchk_en),
    .ctrl_wr   (ctrl_wr),
    .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata),
    .rx_data   (rx_data)
  );

  function automatic logic [7:0] exp_rdata();
    return {fchk_en ? fe : mh, ml, 1'b0, en, 1'b0, nin, 1'b0, flg};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr    = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
    if (fchk_en) fe = v[7];
    else         mh = v[7];
    ml  = v[6];
    en  = v[4];
    nin = v[2];
    flg = v[0];
    @(negedge clk);
  endtask

  task automatic set_chk(input logic v);
    fchk_en = v;
    @(negedge clk);
  endtask

  // drive one frame, check flag timing mid-stop, then update the model
  task automatic run_frame(input logic [8:0] d, input logic stopv, input int gl, input string req);
    logic active;
    int   nb;
    active = en && (mh || ml);
    nb     = mh ? 9 : 8;
    rxd_in = 1'b0;
    ticks(16);
    for (int i = 0; i < nb; i++) begin
      if (i == gl) begin
        rxd_in = d[i];  ticks(8);
        rxd_in = ~d[i]; ticks(1);
        rxd_in = d[i];  ticks(7);
      end else begin
        rxd_in = d[i];
        ticks(16);
      end
    end
    rxd_in = stopv;
    ticks(4);
    chk({req, " R5 flag at quarter stop"}, ctrl_rdata[0], active && !fchk_en);
    ticks(12);
    rxd_in = 1'b1;
    ticks(3);
    if (active) begin
      flg  = 1'b1;
      dexp = d[7:0];
      if (nb == 9) nin = d[8];
      if (fchk_en && !stopv) fe = 1'b1;
    end
    chk({req, " R2 data"}, rx_data, dexp);
    chk({req, " R8 control read"}, ctrl_rdata, exp_rdata());
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; rxd_in = 1'b1; fchk_en = 1'b0; ctrl_wr = 1'b0; ctrl_wdata = '0;
    mh = 0; ml = 0; en = 0; nin = 0; flg = 0; fe = 0; dexp = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, both bit-7 mappings
    chk("R1 rdata check off", ctrl_rdata, 8'h00);
    chk("R1 rx_data", rx_data, 8'h00);
    set_chk(1'b1);
    chk("R1 rdata check on", ctrl_rdata, 8'h00);
    set_chk(1'b0);
    ticks(2);

    // R2 8-bit format, check off (R5: flag at last data bit)
    wr_ctrl(8'h50);
    run_frame(9'h0A5, 1'b1, -1, "R2 fmt01");

    // R2 9-bit format, ninth bit latched
    wr_ctrl(8'hD0);
    run_frame(9'h13C, 1'b1, -1, "R2 fmt11 ninth");
    chk("R2 ninth bit", ctrl_rdata[2], 1'b1);

    // R5 check on moves flag to stop bit
    set_chk(1'b1);
    wr_ctrl(8'h50);          // bit7 -> error flag (0); format-select stays 1
    run_frame(9'h0F0, 1'b1, -1, "R5 check on");
    chk("R5 flag after stop", ctrl_rdata[0], 1'b1);

    // R6 bad stop sets error flag
    wr_ctrl(8'h50);
    run_frame(9'h166, 1'b0, -1, "R6 bad stop");
    chk("R6 error flag set", ctrl_rdata[7], 1'b1);

    // R7 good frame leaves it set
    wr_ctrl(8'hD0);
    run_frame(9'h081, 1'b1, -1, "R7 sticky");
    chk("R7 error flag held", ctrl_rdata[7], 1'b1);

    // R8 bit 7 mapping
    set_chk(1'b0);
    chk("R8 bit7 shows format-select", ctrl_rdata[7], 1'b1);
    wr_ctrl(8'hD0);
    set_chk(1'b1);
    chk("R8 write with check off leaves error flag", ctrl_rdata[7], 1'b1);
    wr_ctrl(8'h50);
    chk("R7 cleared by write", ctrl_rdata[7], 1'b0);
    set_chk(1'b0);
    chk("R8 write with check on leaves format-select", ctrl_rdata[7], 1'b1);
    run_frame(9'h1C3, 1'b1, -1, "R8 still 9-bit");

    // R11 bad stop with check off
    wr_ctrl(8'hD0);
    run_frame(9'h055, 1'b0, -1, "R11 bad stop off");
    set_chk(1'b1);
    chk("R11 no error flag", ctrl_rdata[7], 1'b0);
    set_chk(1'b0);

    // R9 flag written directly
    chk("R9 flag set before write", ctrl_rdata[0], 1'b1);
    wr_ctrl(8'hD0);
    chk("R9 flag cleared by write", ctrl_rdata[0], 1'b0);
    wr_ctrl(8'hD1);
    chk("R9 flag set by write", ctrl_rdata[0], 1'b1);

    // R10 receive disabled, then format 00
    wr_ctrl(8'hC0);
    run_frame(9'h1EE, 1'b1, -1, "R10 rx off");
    chk("R10 flag stays clear", ctrl_rdata[0], 1'b0);
    wr_ctrl(8'h10);
    run_frame(9'h077, 1'b1, -1, "R10 fmt00");
    chk("R10 data unchanged", rx_data, dexp);

    // R4 false start: 4 ticks low then high
    wr_ctrl(8'h50);
    rxd_in = 1'b0; ticks(4);
    rxd_in = 1'b1; ticks(24);
    chk("R4 no flag", ctrl_rdata[0], 1'b0);
    chk("R4 data unchanged", rx_data, dexp);
    run_frame(9'h03A, 1'b1, -1, "R4 recovery");

    // R3 one-tick disturbance in several bits
    for (int g = 0; g < 8; g += 3) begin
      wr_ctrl(8'h50);
      run_frame(9'h0B2 ^ 9'(g), 1'b1, g, "R3 glitch");
    end

    // constrained random frames
    for (int k = 0; k < 40; k++) begin
      logic [1:0] fm;
      logic       ck;
      logic       sv;
      logic [8:0] d;
      fm = 2'($urandom_range(1, 3));
      ck = 1'($urandom_range(0, 1));
      sv = ($urandom_range(0, 4) != 0);
      d  = 9'($urandom);
      set_chk(1'b0);
      wr_ctrl({fm[1], fm[0], 6'b010000});
      set_chk(ck);
      if (ck && $urandom_range(0, 3) == 0) wr_ctrl({1'b0, fm[0], 6'b010000});
      run_frame(d, sv, -1, "R6 R7 random");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule